// File: doc/BRIEF.md
# Smart Card Activation Sequencer

This block runs the power-up sequence for a contact smart card. After a power-on lockout, the host asks for activation with a falling edge on an active-low command line. The block then turns on card VCC and checks that the supply has come up by a fixed deadline. It next puts the I/O lines into reception mode and starts the card clock. Finally it lets the host's reset request reach the card, but only once enough card clock cycles have gone by. All sequencing delays are counted on a timebase tick from a 1.5 MHz oscillator. The reset hold-off is counted on a separate card-clock tick.

If the supply does not come up, the block flags a fault to the host on an active-low output and drops power. The host, a card removal or an internal fault can end an active session at any point. Analog regulation, clock division and pad drivers sit outside this block. The block only produces the enables for them.

Top module: `card_act_seq`

## Requirements
- R1: After reset, and again each time `supply_fault` clears, `lock_done` is low until LOCK_TICKS `osc_tick` pulses have been seen with `supply_fault` low. While it is low, a falling edge on `cmd_n` does not activate the card.
- R2: Activation is started by a falling edge of `cmd_n` (1 to 0 between two clocks). Holding `cmd_n` low does not start a new activation.
- R3: An activation edge is refused when `card_present` is 0, `overtemp` is 1 or `supply_fault` is 1. The block then stays idle with all enables low.
- R4: An accepted activation raises `vcc_en` on the next clock. On the VCC_CHK_TICKS-th `osc_tick` after that, `vcc_ok` is sampled.
- R5: If `vcc_ok` is 0 at that sample, `fault_n` goes to 0 and `vcc_en` goes to 0 on the same clock. The block returns to idle.
- R6: If `vcc_ok` is 1 at that sample, `io_rx_en` goes to 1 on the IO_TICKS-th `osc_tick` after the sample.
- R7: `cclk_en` goes to 1 on the CLK_TICKS-th `osc_tick` after `io_rx_en` rose.
- R8: While `cclk_en` is 1, `card_rst` is 0 until RST_CYCLES `cclk_tick` pulses have been seen. After that, `card_rst` equals `host_rst`, even if `host_rst` was raised earlier. The count saturates.
- R9: `fault_n` is 1 after reset. Once low, it stays low, including through idle and refused requests, until the next accepted activation sets it back to 1.
- R10: In any active state, any of these events returns the block to idle with `vcc_en`, `io_rx_en`, `cclk_en` and `card_rst` all 0: a rising edge of `cmd_n`, `card_present` = 0, `overtemp` = 1 or `supply_fault` = 1. An `overtemp` or `supply_fault` abort also drives `fault_n` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle pulse per 1.5 MHz oscillator period |
| cclk_tick | input | 1 | One-cycle pulse per card clock period |
| cmd_n | input | 1 | Active-low activation command (edge sensitive) |
| host_rst | input | 1 | Host's requested card reset level |
| card_present | input | 1 | Card inserted |
| overtemp | input | 1 | Over-temperature fault |
| supply_fault | input | 1 | Supply below fail threshold |
| vcc_ok | input | 1 | Card VCC within range |
| vcc_en | output | 1 | Card VCC enable |
| io_rx_en | output | 1 | I/O lines in reception mode |
| cclk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset output |
| fault_n | output | 1 | Active-low fault flag to host |

## Verification
The bench attacks the lockout window, the edge rule for the command line and the refused requests. A design that acted on levels, or that ignored the lockout, would raise `vcc_en` where the model keeps it low. It also drives `vcc_ok` low at the deadline and raises `host_rst` long before the clock starts. A wrong deadline or a missing hold-off would show up as a fault, or a reset edge, one or more cycles away from the model's. Mid-sequence aborts and the stickiness of the fault flag across idle and refused requests are compared on every cycle.

// File: rtl/card_act_pkg.sv
package card_act_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWR,
        ST_IO,
        ST_CLK,
        ST_RUN
    } act_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/card_act_lockout.sv
module card_act_lockout #(
    parameter int LOCK_TICKS = 15000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic supply_fault,
    output logic lock_done
);
    localparam int CW = $clog2(LOCK_TICKS + 1);
    localparam logic [CW-1:0] TERM = CW'(LOCK_TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (supply_fault)
            cnt_d = '0;
        else if (osc_tick && cnt_q != TERM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign lock_done = (cnt_q == TERM);

    // R1
    lock_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        supply_fault |=> !lock_done);
    // R1
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_done) |-> $past(osc_tick && !supply_fault));
endmodule

// File: rtl/card_act_rst_gate.sv
module card_act_rst_gate #(
    parameter int RST_CYCLES = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic cclk_tick,
    output logic gate_done
);
    localparam int CW = $clog2(RST_CYCLES + 1);
    localparam logic [CW-1:0] TERM = CW'(RST_CYCLES);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cclk_tick && cnt_q != TERM)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign gate_done = (cnt_q == TERM);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TERM);
    // R8
    gate_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_done) |-> $past(run && cclk_tick));
    // R8
    gate_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gate_done |-> $past(run));
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
    import card_act_pkg::*;
#(
    parameter int LOCK_TICKS    = 15000,
    parameter int VCC_CHK_TICKS = 765,
    parameter int IO_TICKS      = 4,
    parameter int CLK_TICKS     = 1,
    parameter int RST_CYCLES    = 42000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic cclk_tick,
    input  logic cmd_n,
    input  logic host_rst,
    input  logic card_present,
    input  logic overtemp,
    input  logic supply_fault,
    input  logic vcc_ok,
    output logic vcc_en,
    output logic io_rx_en,
    output logic cclk_en,
    output logic card_rst,
    output logic fault_n
);
    localparam int TMAX = max3(VCC_CHK_TICKS, IO_TICKS, CLK_TICKS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] VCC_LAST = TW'(VCC_CHK_TICKS - 1);
    localparam logic [TW-1:0] IO_LAST  = TW'(IO_TICKS - 1);
    localparam logic [TW-1:0] CLK_LAST = TW'(CLK_TICKS - 1);

    typedef struct packed {
        act_state_e    state;
        logic [TW-1:0] tmr;
        logic          fault;
        logic          cmd_prev;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic lock_done, gate_done;
    logic cmd_fall, cmd_rise, blocked, hard_fault;

    card_act_lockout #(.LOCK_TICKS(LOCK_TICKS)) u_lockout (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .supply_fault(supply_fault), .lock_done(lock_done)
    );

    card_act_rst_gate #(.RST_CYCLES(RST_CYCLES)) u_rst_gate (
        .clk(clk), .rst_n(rst_n), .run(r_q.state == ST_RUN),
        .cclk_tick(cclk_tick), .gate_done(gate_done)
    );

    always_comb begin
        r_d          = r_q;
        r_d.cmd_prev = cmd_n;
        cmd_fall     = r_q.cmd_prev && !cmd_n;
        cmd_rise     = !r_q.cmd_prev && cmd_n;
        hard_fault   = overtemp || supply_fault;
        blocked      = !card_present || hard_fault;

        if (r_q.state != ST_IDLE && (cmd_rise || blocked)) begin
            r_d.state = ST_IDLE;
            r_d.tmr   = '0;
            if (hard_fault) r_d.fault = 1'b1;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (cmd_fall && lock_done && !blocked) begin
                        r_d.state = ST_PWR;
                        r_d.tmr   = '0;
                        r_d.fault = 1'b0;
                    end
                end
                ST_PWR: begin
                    if (osc_tick) begin
                        if (r_q.tmr == VCC_LAST) begin
                            r_d.tmr = '0;
                            if (vcc_ok) begin
                                r_d.state = ST_IO;
                            end else begin
                                r_d.state = ST_IDLE;
                                r_d.fault = 1'b1;
                            end
                        end else begin
                            r_d.tmr = r_q.tmr + 1'b1;
                        end
                    end
                end
                ST_IO: begin
                    if (osc_tick) begin
                        if (r_q.tmr == IO_LAST) begin
                            r_d.tmr   = '0;
                            r_d.state = ST_CLK;
                        end else begin
                            r_d.tmr = r_q.tmr + 1'b1;
                        end
                    end
                end
                ST_CLK: begin
                    if (osc_tick) begin
                        if (r_q.tmr == CLK_LAST) begin
                            r_d.tmr   = '0;
                            r_d.state = ST_RUN;
                        end else begin
                            r_d.tmr = r_q.tmr + 1'b1;
                        end
                    end
                end
                ST_RUN:  ;
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_IDLE;
            r_q.tmr      <= '0;
            r_q.fault    <= 1'b0;
            r_q.cmd_prev <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign vcc_en   = (r_q.state != ST_IDLE);
    assign io_rx_en = (r_q.state == ST_CLK) || (r_q.state == ST_RUN);
    assign cclk_en  = (r_q.state == ST_RUN);
    assign card_rst = cclk_en && gate_done && host_rst;
    assign fault_n  = !r_q.fault;

    // R1
    act_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> $past(lock_done));
    // R3
    act_precond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> $past(card_present && !overtemp && !supply_fault));
    // R2
    act_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vcc_en) |-> ($past(cmd_n, 2) && !$past(cmd_n)));
    // R5
    fault_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> (!vcc_en && $past(vcc_en)));
    // R6
    io_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_rx_en) |-> ($past(osc_tick) && vcc_en));
    // R7
    clk_after_io_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cclk_en) |-> ($past(io_rx_en) && $past(osc_tick)));
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_en && !card_present) |=> !vcc_en);
endmodule

// File: tb/card_act_seq_bench.sv
module card_act_seq_bench;
    localparam int LOCK = 20, VCCT = 10, IOT = 4, CLKT = 1, RSTC = 50;

    logic clk = 1'b0, rst_n = 1'b0;
    logic osc_tick = 1'b0, cclk_tick = 1'b0;
    logic cmd_n = 1'b1, host_rst = 1'b0, card_present = 1'b1;
    logic overtemp = 1'b0, supply_fault = 1'b0, vcc_ok = 1'b1;
    logic vcc_en, io_rx_en, cclk_en, card_rst, fault_n;

    int n_chk = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    card_act_seq #(.LOCK_TICKS(LOCK), .VCC_CHK_TICKS(VCCT), .IO_TICKS(IOT),
                   .CLK_TICKS(CLKT), .RST_CYCLES(RSTC)) u_card_act_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cclk_tick(cclk_tick),
        .cmd_n(cmd_n), .host_rst(host_rst), .card_present(card_present),
        .overtemp(overtemp), .supply_fault(supply_fault), .vcc_ok(vcc_ok),
        .vcc_en(vcc_en), .io_rx_en(io_rx_en), .cclk_en(cclk_en),
        .card_rst(card_rst), .fault_n(fault_n)
    );

    // free-running tick patterns
    always @(negedge clk) begin
        cyc       <= cyc + 1;
        osc_tick  <= (cyc % 2) == 0;
        cclk_tick <= (cyc % 3) != 0;
    end

    // behavioural reference model
    int  m_lock, m_ph, m_t, m_rc;
    bit  m_fault, m_prev;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lock = 0; m_ph = 0; m_t = 0; m_rc = 0; m_fault = 0; m_prev = 1;
        end else begin
            bit fall, rise, bad, ldone;
            fall  = m_prev && !cmd_n;
            rise  = !m_prev && cmd_n;
            bad   = !card_present || overtemp || supply_fault;
            ldone = (m_lock >= LOCK);
            if (m_ph != 4) m_rc = 0;
            else if (cclk_tick && m_rc < RSTC) m_rc++;
            if (supply_fault) m_lock = 0;
            else if (osc_tick && m_lock < LOCK) m_lock++;
            if (m_ph != 0 && (rise || bad)) begin
                if (overtemp || supply_fault) m_fault = 1;
                m_ph = 0; m_t = 0;
            end else if (m_ph == 0) begin
                if (fall && ldone && !bad) begin m_ph = 1; m_t = 0; m_fault = 0; end
            end else if (m_ph != 4 && osc_tick) begin
                m_t++;
                if (m_ph == 1 && m_t == VCCT) begin
                    m_t = 0;
                    if (vcc_ok) m_ph = 2; else begin m_ph = 0; m_fault = 1; end
                end else if (m_ph == 2 && m_t == IOT) begin m_t = 0; m_ph = 3; end
                else if (m_ph == 3 && m_t == CLKT) begin m_t = 0; m_ph = 4; end
            end
            m_prev = cmd_n;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // per-cycle compare, away from both edges
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            chk("R4 vcc_en", vcc_en, m_ph != 0);
            chk("R6 io_rx_en", io_rx_en, m_ph >= 3);
            chk("R7 cclk_en", cclk_en, m_ph == 4);
            chk("R8 card_rst", card_rst, (m_ph == 4) && (m_rc >= RSTC) && host_rst);
            chk("R9 fault_n", fault_n, !m_fault);
        end
    end

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_act();
        @(negedge clk) cmd_n = 1'b1;
        wait_cyc(2);
        @(negedge clk) cmd_n = 1'b0;
    endtask

    task automatic sample();
        @(negedge clk); #3;
    endtask

    initial begin
        wait_cyc(3);
        #3;
        chk("R9 reset fault_n", fault_n, 1'b1);
        chk("R10 reset vcc_en", vcc_en, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        // R1: request inside lockout is ignored
        wait_cyc(3);
        @(negedge clk) cmd_n = 1'b0;
        wait_cyc(4); sample();
        chk("R1 lockout ignore", vcc_en, 1'b0);
        // R2: level held low after lockout does not activate
        wait_cyc(60); sample();
        chk("R2 level no act", vcc_en, 1'b0);
        // R8: host reset raised early, held off
        host_rst = 1'b1;
        pulse_act();
        sample();
        chk("R4 activate", vcc_en, 1'b1);
        while (!cclk_en) sample();
        chk("R8 held off", card_rst, 1'b0);
        wait_cyc(90); sample();
        chk("R8 passes host_rst", card_rst, 1'b1);
        @(negedge clk) host_rst = 1'b0;
        sample();
        chk("R8 follows host_rst", card_rst, 1'b0);
        // R10: rising command edge ends session
        @(negedge clk) cmd_n = 1'b1;
        wait_cyc(2); sample();
        chk("R10 cmd rise idle", vcc_en, 1'b0);
        // R3: refused with card absent
        card_present = 1'b0;
        pulse_act();
        wait_cyc(3); sample();
        chk("R3 no card refused", vcc_en, 1'b0);
        card_present = 1'b1;
        // R5: VCC never valid
        vcc_ok = 1'b0;
        pulse_act();
        wait_cyc(40); sample();
        chk("R5 fault raised", fault_n, 1'b0);
        chk("R5 vcc off", vcc_en, 1'b0);
        vcc_ok = 1'b1;
        // R9: refused request keeps fault
        overtemp = 1'b1;
        pulse_act();
        wait_cyc(3); sample();
        chk("R9 fault kept", fault_n, 1'b0);
        overtemp = 1'b0;
        pulse_act();
        wait_cyc(2); sample();
        chk("R9 fault cleared", fault_n, 1'b1);
        // R10: card removed mid power phase
        wait_cyc(4);
        @(negedge clk) card_present = 1'b0;
        wait_cyc(2); sample();
        chk("R10 removal idle", vcc_en, 1'b0);
        card_present = 1'b1;
        // R10: overtemp in run
        pulse_act();
        while (!cclk_en) sample();
        @(negedge clk) overtemp = 1'b1;
        wait_cyc(2); sample();
        chk("R10 overtemp idle", cclk_en, 1'b0);
        chk("R10 overtemp fault", fault_n, 1'b0);
        overtemp = 1'b0;
        // R1: supply fault restarts lockout
        @(negedge clk) supply_fault = 1'b1;
        wait_cyc(3);
        @(negedge clk) supply_fault = 1'b0;
        pulse_act();
        wait_cyc(3); sample();
        chk("R1 relock ignore", vcc_en, 1'b0);
        wait_cyc(60);
        pulse_act();
        wait_cyc(2); sample();
        chk("R1 after relock", vcc_en, 1'b1);
        // R6 R7: a full sequence is compared cycle by cycle
        wait_cyc(60);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule